// File: doc/BRIEF.md
# Secondary Interrupt Controller with Direct Line Routing

This block collects 32 level-sensitive interrupt requests from peripherals and presents them to a primary interrupt controller over a 32-line upstream bus. Every request is captured in a raw level word each clock. A software-controlled enable mask gates the raw levels, and the gated levels are ORed into one summary request. The summary request always leaves on upstream line 31.

Lines 21 to 30 can also bypass the summary path. When its route enable bit is set, each of these inputs drives the upstream line with the same number directly. Upstream lines 0 to 20 are never driven. Software reaches the mask and the route enables through a small memory-mapped window of 4 KB. Each register has a separate write port that sets bits and one that clears bits, so software never needs a read-modify-write.

The bus takes a single-cycle request made of valid, write, byte address and write data. Read data comes back on the cycle after the request. The word index is the byte address with its two low bits dropped.

Top module: `sec_irq_ctrl`

## Requirements
- R1: An active-low asynchronous reset clears the enable mask, the route enables, the raw level word, the upstream lines and the read data. Reset is released through a two-stage synchronizer.
- R2: The raw level word is sampled from `irq_in` on every clock. Reading word 1 returns the raw level word. Reading word 0 returns the raw level word ANDed with the enable mask. Reading word 2 returns the enable mask. Read data is valid in the cycle after the request.
- R3: A write to word 2 ORs the write data into the enable mask. A write to word 3 clears every mask bit that is 1 in the write data.
- R4: Reading word 4 returns raw level bit 0 in bit 0 and zeros elsewhere. A write of any nonzero value to word 4 sets mask bit 0, and a nonzero write to word 5 clears it. A zero write to word 4 or word 5 changes nothing.
- R5: Reading word 8 returns the route enables. A write to word 8 ORs in the write data ANDed with 0x7FE00000, so only bits 21 to 30 can ever be set. A write to word 9 clears the route enable bits that are 1 in the write data.
- R6: `up_irq[31]` is 1 exactly when (raw level AND mask) is nonzero. The value is registered, so it follows `irq_in` two clocks after the input changes and follows a register write one clock after the write.
- R7: For each i from 21 to 30, `up_irq[i]` equals raw level bit i when route enable bit i is set, and is 0 otherwise. It has the same latency as R6.
- R8: `up_irq[20:0]` is always 0. Bit 31 of `irq_in` never reaches `up_irq[31]` except through the masked summary.
- R9: Reads of any word index other than 0, 1, 2, 4 and 8 return 0. Writes to any word index other than 2, 3, 4, 5, 8 and 9 change no state. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Level-sensitive interrupt requests |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address inside the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read, otherwise 0 |
| up_irq | output | 32 | Upstream lines: bit 31 is the summary, bits 21..30 are routed inputs |

## Verification
The bench targets the following corner cases:

- **Route mask.** A write of all ones to the route set port must leave only bits 21 to 30 enabled. A design that skipped the mask would leak input 31 or low inputs onto upstream lines.
- **Bit-0 set and clear ports.** Zero writes to words 4 and 5 must do nothing. A design that treated these ports as plain data writes would clear or set the whole mask.
- **Undefined words and address bits.** Undefined words must read 0 and must not alter state when written. Address bits 1:0 must be ignored; a decoder that used them would alias registers.
- **Output latency.** The bench samples the outputs at the exact cycle given in R6 and R7. An extra or missing pipeline stage would show up as a check one cycle off.
- **Asynchronous reset.** A reset applied in the middle of a run must clear the outputs at once. It must not wait for a clock edge.

// File: rtl/sec_irq_pkg.sv
package sec_irq_pkg;

  // Bit vector with ones from lo to hi inclusive (up to 64 lines).
  function automatic logic [63:0] span_mask(input int lo, input int hi);
    logic [63:0] m;
    for (int i = 0; i < 64; i++) begin
      m[i] = (i >= lo) && (i <= hi);
    end
    return m;
  endfunction

endpackage

// File: rtl/sec_irq_rstsync.sv
module sec_irq_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;
  logic out_q;

  // Assert asynchronously, release after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;

endmodule

// File: rtl/sec_irq_sample.sv
module sec_irq_sample #(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  output logic [NUM_LINES-1:0] raw_q
);

  logic [NUM_LINES-1:0] raw_d;

  always_comb begin
    raw_d = irq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_d;
  end

endmodule

// File: rtl/sec_irq_regs.sv
module sec_irq_regs #(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 12,
  parameter int THRU_LO   = 21,
  parameter int THRU_HI   = 30
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [NUM_LINES-1:0] bus_wdata,
  input  logic [NUM_LINES-1:0] raw_q,
  output logic [NUM_LINES-1:0] mask_q,
  output logic [NUM_LINES-1:0] thru_q,
  output logic [NUM_LINES-1:0] bus_rdata
);

  import sec_irq_pkg::*;

  localparam int IDX_W = ADDR_W - 2;
  localparam logic [63:0] THRU_M64 = span_mask(THRU_LO, THRU_HI);
  localparam logic [NUM_LINES-1:0] THRU_MASK = THRU_M64[NUM_LINES-1:0];

  // Word indices of the register window.
  localparam logic [IDX_W-1:0] W_PEND     = IDX_W'(0);
  localparam logic [IDX_W-1:0] W_RAW      = IDX_W'(1);
  localparam logic [IDX_W-1:0] W_ENA_SET  = IDX_W'(2);
  localparam logic [IDX_W-1:0] W_ENA_CLR  = IDX_W'(3);
  localparam logic [IDX_W-1:0] W_SOFT_SET = IDX_W'(4);
  localparam logic [IDX_W-1:0] W_SOFT_CLR = IDX_W'(5);
  localparam logic [IDX_W-1:0] W_THRU_SET = IDX_W'(8);
  localparam logic [IDX_W-1:0] W_THRU_CLR = IDX_W'(9);

  logic [IDX_W-1:0]     idx;
  logic                 unused_lsb;
  logic                 wr_req;
  logic                 rd_req;
  logic                 wdata_nz;
  logic [NUM_LINES-1:0] mask_d;
  logic [NUM_LINES-1:0] thru_d;
  logic [NUM_LINES-1:0] rdata_d;
  logic                 mask_en;
  logic                 thru_en;

  assign idx        = bus_addr[ADDR_W-1:2];
  assign unused_lsb = ^bus_addr[1:0];
  assign wr_req     = bus_valid & bus_write;
  assign rd_req     = bus_valid & ~bus_write;
  assign wdata_nz   = |bus_wdata;

  // Write path: next-state values and clock enables.
  always_comb begin
    mask_d  = mask_q;
    thru_d  = thru_q;
    mask_en = 1'b0;
    thru_en = 1'b0;
    if (wr_req) begin
      case (idx)
        W_ENA_SET: begin
          mask_d  = mask_q | bus_wdata;
          mask_en = 1'b1;
        end
        W_ENA_CLR: begin
          mask_d  = mask_q & ~bus_wdata;
          mask_en = 1'b1;
        end
        W_SOFT_SET: begin
          mask_d[0] = 1'b1;
          mask_en   = wdata_nz;
        end
        W_SOFT_CLR: begin
          mask_d[0] = 1'b0;
          mask_en   = wdata_nz;
        end
        W_THRU_SET: begin
          thru_d  = thru_q | (bus_wdata & THRU_MASK);
          thru_en = 1'b1;
        end
        W_THRU_CLR: begin
          thru_d  = thru_q & ~bus_wdata;
          thru_en = 1'b1;
        end
        default: begin
          mask_en = 1'b0;
          thru_en = 1'b0;
        end
      endcase
    end
  end

  // Read path: data returned the following cycle, zero when idle.
  always_comb begin
    rdata_d = '0;
    if (rd_req) begin
      case (idx)
        W_PEND:     rdata_d = raw_q & mask_q;
        W_RAW:      rdata_d = raw_q;
        W_ENA_SET:  rdata_d = mask_q;
        W_SOFT_SET: rdata_d = {{(NUM_LINES-1){1'b0}}, raw_q[0]};
        W_THRU_SET: rdata_d = thru_q;
        default:    rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thru_q <= '0;
    end else if (thru_en) begin
      thru_q <= thru_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= rdata_d;
    end
  end

endmodule

// File: rtl/sec_irq_route.sv
module sec_irq_route #(
  parameter int NUM_LINES = 32,
  parameter int THRU_LO   = 21,
  parameter int THRU_HI   = 30,
  parameter int SUM_LINE  = 31
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] raw_q,
  input  logic [NUM_LINES-1:0] mask_q,
  input  logic [NUM_LINES-1:0] thru_q,
  output logic [NUM_LINES-1:0] up_irq_q
);

  logic [NUM_LINES-1:0] up_d;
  logic                 summary;

  assign summary = |(raw_q & mask_q);

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    if (i == SUM_LINE) begin : g_sum
      assign up_d[i] = summary;
    end else if ((i >= THRU_LO) && (i <= THRU_HI)) begin : g_thru
      assign up_d[i] = raw_q[i] & thru_q[i];
    end else begin : g_tied
      assign up_d[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_irq_q <= '0;
    else        up_irq_q <= up_d;
  end

endmodule

// File: rtl/sec_irq_ctrl.sv
module sec_irq_ctrl #(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 12,
  parameter int THRU_LO   = 21,
  parameter int THRU_HI   = 30,
  parameter int SUM_LINE  = 31
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [NUM_LINES-1:0] bus_wdata,
  output logic [NUM_LINES-1:0] bus_rdata,
  output logic [NUM_LINES-1:0] up_irq
);

  logic                 rst_sync_n;
  logic [NUM_LINES-1:0] raw_q;
  logic [NUM_LINES-1:0] mask_q;
  logic [NUM_LINES-1:0] thru_q;

  sec_irq_rstsync rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sec_irq_sample #(.NUM_LINES(NUM_LINES)) smp_i (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .irq_in (irq_in),
    .raw_q  (raw_q)
  );

  sec_irq_regs #(
    .NUM_LINES (NUM_LINES),
    .ADDR_W    (ADDR_W),
    .THRU_LO   (THRU_LO),
    .THRU_HI   (THRU_HI)
  ) regs_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .raw_q     (raw_q),
    .mask_q    (mask_q),
    .thru_q    (thru_q),
    .bus_rdata (bus_rdata)
  );

  sec_irq_route #(
    .NUM_LINES (NUM_LINES),
    .THRU_LO   (THRU_LO),
    .THRU_HI   (THRU_HI),
    .SUM_LINE  (SUM_LINE)
  ) route_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .raw_q    (raw_q),
    .mask_q   (mask_q),
    .thru_q   (thru_q),
    .up_irq_q (up_irq)
  );

endmodule

// File: rtl/sec_irq_chk.sv
module sec_irq_chk #(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 12,
  parameter int THRU_LO   = 21,
  parameter int THRU_HI   = 30,
  parameter int SUM_LINE  = 31
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINES-1:0] irq_in,
  input logic                 bus_valid,
  input logic                 bus_write,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [NUM_LINES-1:0] bus_wdata,
  input logic [NUM_LINES-1:0] bus_rdata,
  input logic [NUM_LINES-1:0] raw_q,
  input logic [NUM_LINES-1:0] mask_q,
  input logic [NUM_LINES-1:0] thru_q,
  input logic [NUM_LINES-1:0] up_irq
);

  import sec_irq_pkg::*;

  localparam int IDX_W = ADDR_W - 2;
  localparam logic [63:0] THRU_M64 = span_mask(THRU_LO, THRU_HI);
  localparam logic [NUM_LINES-1:0] THRU_MASK = THRU_M64[NUM_LINES-1:0];

  logic [IDX_W-1:0] idx;
  logic             unused_lsb;
  logic             wr;
  logic             rd;
  logic             rd_undef;

  assign idx        = bus_addr[ADDR_W-1:2];
  assign unused_lsb = ^bus_addr[1:0];
  assign wr         = bus_valid & bus_write;
  assign rd         = bus_valid & ~bus_write;
  assign rd_undef   = rd && (idx != IDX_W'(0)) && (idx != IDX_W'(1)) &&
                      (idx != IDX_W'(2)) && (idx != IDX_W'(4)) && (idx != IDX_W'(8));

  assert_raw_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> raw_q == $past(irq_in));

  assert_ena_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == IDX_W'(2)) |=> mask_q == $past(mask_q | bus_wdata));

  assert_ena_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == IDX_W'(3)) |=> mask_q == $past(mask_q & ~bus_wdata));

  assert_soft_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == IDX_W'(5) && |bus_wdata) |=> !mask_q[0]);

  assert_thru_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == IDX_W'(8)) |=> thru_q == $past(thru_q | (bus_wdata & THRU_MASK)));

  assert_summary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> up_irq[SUM_LINE] == $past(|(raw_q & mask_q)));

  assert_thru_lines_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (up_irq & THRU_MASK) == $past(raw_q & thru_q & THRU_MASK));

  assert_low_lines_R8: assert property (@(posedge clk) disable iff (!rst_n)
    up_irq[THRU_LO-1:0] == '0);

  assert_rd_undef_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_undef |=> bus_rdata == '0);

endmodule

bind sec_irq_ctrl sec_irq_chk #(
  .NUM_LINES (NUM_LINES),
  .ADDR_W    (ADDR_W),
  .THRU_LO   (THRU_LO),
  .THRU_HI   (THRU_HI),
  .SUM_LINE  (SUM_LINE)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .irq_in    (irq_in),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .raw_q     (raw_q),
  .mask_q    (mask_q),
  .thru_q    (thru_q),
  .up_irq    (up_irq)
);

// File: tb/sec_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module sec_irq_ctrl_tb_top;

  localparam int N = 32;
  localparam int AW = 12;
  localparam int NV = 10;
  localparam logic [31:0] THRU_M = 32'h7FE0_0000;

  // Stimulus vectors: input levels, word index written, write data.
  localparam logic [31:0] V_IRQ [NV] = '{
    32'h0000_0011, 32'h0000_0011, 32'h8060_0000, 32'h7FE0_0000, 32'h0000_0001,
    32'h0000_0001, 32'h0000_0001, 32'h4000_0001, 32'hFFFF_FFFF, 32'hFFFF_FFFF };
  localparam logic [31:0] V_IDX [NV] = '{
    32'd2, 32'd3, 32'd8, 32'd9, 32'd4, 32'd4, 32'd5, 32'd5, 32'd6, 32'd2 };
  localparam logic [31:0] V_DAT [NV] = '{
    32'h0000_0010, 32'h0000_0010, 32'hFFFF_FFFF, 32'h0020_0000, 32'h0000_0005,
    32'h0000_0000, 32'h0000_0000, 32'h0000_0080, 32'hFFFF_FFFF, 32'h8000_0000 };

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  irq_in;
  logic          bus_valid;
  logic          bus_write;
  logic [AW-1:0] bus_addr;
  logic [N-1:0]  bus_wdata;
  logic [N-1:0]  bus_rdata;
  logic [N-1:0]  up_irq;

  int total = 0;
  int bad = 0;

  logic [31:0] m_mask;
  logic [31:0] m_thru;
  logic [31:0] m_lvl;
  logic [31:0] rd_val;

  sec_irq_ctrl dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .up_irq    (up_irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [31:0] idx, input logic [31:0] data);
    @(negedge clk);
    bus_valid = 1'b1;
    bus_write = 1'b1;
    bus_addr  = AW'(idx << 2);
    bus_wdata = data;
    @(negedge clk);
    bus_valid = 1'b0;
    bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] addr, output logic [31:0] data);
    @(negedge clk);
    bus_valid = 1'b1;
    bus_write = 1'b0;
    bus_addr  = addr;
    @(negedge clk);
    bus_valid = 1'b0;
    data = bus_rdata;
  endtask

  // Reference model of the register write ports.
  task automatic model_wr(input logic [31:0] idx, input logic [31:0] data);
    case (idx)
      32'd2: m_mask = m_mask | data;
      32'd3: m_mask = m_mask & ~data;
      32'd4: if (data != 0) m_mask[0] = 1'b1;
      32'd5: if (data != 0) m_mask[0] = 1'b0;
      32'd8: m_thru = m_thru | (data & THRU_M);
      32'd9: m_thru = m_thru & ~data;
      default: ;
    endcase
  endtask

  function automatic logic [31:0] model_up(input logic [31:0] lvl, input logic [31:0] msk,
                                           input logic [31:0] thr);
    logic [31:0] r;
    r = lvl & thr & THRU_M;
    r[31] = |(lvl & msk);
    return r;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_mask = '0;
    m_thru = '0;
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired R1 actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    irq_in = '0;
    bus_valid = 1'b0;
    bus_write = 1'b0;
    bus_addr = '0;
    bus_wdata = '0;
    m_mask = '0;
    m_thru = '0;
    m_lvl = '0;
    irq_in = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    // R1: outputs held at zero during reset even with inputs active
    check("R1 up_irq in reset", up_irq, 32'h0);
    check("R1 rdata in reset", bus_rdata, 32'h0);
    irq_in = '0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_rd(AW'(2 << 2), rd_val); check("R1 mask after reset", rd_val, 32'h0);
    bus_rd(AW'(8 << 2), rd_val); check("R1 route enable after reset", rd_val, 32'h0);
    check("R1 up_irq after reset", up_irq, 32'h0);

    // Vector walk against the reference model (R2 R3 R4 R5 R6 R7 R8 R9)
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      irq_in = V_IRQ[v];
      m_lvl = V_IRQ[v];
      bus_wr(V_IDX[v], V_DAT[v]);
      model_wr(V_IDX[v], V_DAT[v]);
      @(negedge clk);
      check("R6 R7 R8 vector up_irq", up_irq, model_up(m_lvl, m_mask, m_thru));
      bus_rd(AW'(0), rd_val);      check("R2 vector pending", rd_val, m_lvl & m_mask);
      bus_rd(AW'(1 << 2), rd_val); check("R2 vector raw", rd_val, m_lvl);
      bus_rd(AW'(2 << 2), rd_val); check("R3 R4 R9 vector mask", rd_val, m_mask);
      bus_rd(AW'(8 << 2), rd_val); check("R5 vector route enable", rd_val, m_thru);
    end

    // R4: soft read returns raw bit 0 only
    @(negedge clk); irq_in = 32'h0000_0003;
    repeat (2) @(negedge clk);
    bus_rd(AW'(4 << 2), rd_val); check("R4 soft read bit0 set", rd_val, 32'h1);
    @(negedge clk); irq_in = 32'h0000_0002;
    repeat (2) @(negedge clk);
    bus_rd(AW'(4 << 2), rd_val); check("R4 soft read bit0 clear", rd_val, 32'h0);

    // R9: undefined reads are zero, low address bits ignored
    bus_rd(AW'(3 << 2), rd_val);   check("R9 read word3", rd_val, 32'h0);
    bus_rd(AW'(5 << 2), rd_val);   check("R9 read word5", rd_val, 32'h0);
    bus_rd(AW'(9 << 2), rd_val);   check("R9 read word9", rd_val, 32'h0);
    bus_rd(AW'(12'hFFC), rd_val);  check("R9 read top word", rd_val, 32'h0);
    bus_rd(AW'((2 << 2) | 3), rd_val); check("R9 low address bits ignored", rd_val, m_mask);
    bus_wr(32'd1023, 32'hFFFF_FFFF);
    bus_rd(AW'(2 << 2), rd_val); check("R9 write top word mask", rd_val, m_mask);
    bus_rd(AW'(8 << 2), rd_val); check("R9 write top word route", rd_val, m_thru);

    // R6 latency: input to summary takes two clocks
    do_reset();
    bus_wr(32'd2, 32'h0000_0020);
    @(negedge clk); irq_in = 32'h0000_0020;
    @(negedge clk); check("R6 summary one clock after input", {31'h0, up_irq[31]}, 32'h0);
    @(negedge clk); check("R6 summary two clocks after input", {31'h0, up_irq[31]}, 32'h1);
    // write to output takes one clock
    bus_wr(32'd3, 32'h0000_0020);
    check("R6 summary before output stage", {31'h0, up_irq[31]}, 32'h1);
    @(negedge clk); check("R6 summary one clock after clear", {31'h0, up_irq[31]}, 32'h0);

    // R8 R5: all inputs, all enables
    @(negedge clk); irq_in = 32'hFFFF_FFFF;
    bus_wr(32'd2, 32'hFFFF_FFFF);
    bus_wr(32'd8, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R8 low lines tied, R7 routed lines", up_irq, 32'hFFE0_0000);
    bus_wr(32'd2, 32'h0);
    bus_wr(32'd3, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R8 line31 without mask", up_irq, 32'h7FE0_0000);

    // R1: asynchronous reset clears outputs without a clock edge
    @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5 check("R1 async reset clears up_irq", up_irq, 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_rd(AW'(8 << 2), rd_val); check("R1 route enable cleared by reset", rd_val, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule